// File: doc/BRIEF.md
# Packed Halfword Signed Add Unit

This block is the execute stage for one instruction that adds two pairs of signed 16-bit values at once. A 32-bit source word holds two halfword lanes. The unit adds the matching lanes of two source words, with no carry between lanes, and returns the packed 32-bit result. For each lane it also returns a pair of greater-or-equal flag bits that record whether the exact, untruncated sum was non-negative. If the sum overflows, the stored halfword wraps but the flag pair still shows the true sign.

Each cycle the unit can accept one instruction word with a valid strobe, the four current condition flags (negative, zero, carry, overflow) and the two operand words from the register file. It drives the two source register indices back to the register file as plain wires. It then checks the fixed bits of the word and tests the condition field against the flags. One cycle later it delivers the result, the destination index, a write enable and a GE update enable. A word whose fixed bits do not match, or whose condition field is 4'b1111, raises the illegal flag instead. The unit has no output for the negative, zero, carry or overflow flags, so it never changes them.

Top module: `phadd_unit`

## Requirements
- R1: Result bits 15:0 are the low 16 bits of the sum of the operands' bits 15:0. Result bits 31:16 are the low 16 bits of the sum of the operands' bits 31:16. Overflow wraps and no carry passes from the low lane to the high lane.
- R2: ge_out[1:0] is 2'b11 when the exact signed sum of the low lanes is zero or more, and 2'b00 when it is negative.
- R3: ge_out[3:2] is 2'b11 when the exact signed sum of the high lanes is zero or more, and 2'b00 when it is negative.
- R4: A word is legal only when bits 27:20 are 8'h61, bits 11:8 are 4'hF and bits 7:4 are 4'h1. A valid word that breaks any of these sets illegal for one cycle, keeps res_we and ge_we low, and leaves res_data, res_rd and ge_out unchanged.
- R5: A valid word with correct fixed bits and condition field (bits 31:28) equal to 4'hF is handled like R4: illegal is set, nothing is written and the outputs are held.
- R6: The condition codes are 0 EQ (Z), 1 NE (!Z), 2 CS (C), 3 CC (!C), 4 MI (N), 5 PL (!N), 6 VS (V), 7 VC (!V), 8 HI (C&!Z), 9 LS (!C|Z), 10 GE (N==V), 11 LT (N!=V), 12 GT (!Z&N==V), 13 LE (Z|N!=V), 14 always. When the condition passes, res_we and ge_we are both set. When it fails, both stay low, illegal stays low and the outputs hold their values.
- R7: All results appear on the first rising edge after the edge that samples in_valid. res_we and ge_we are set for exactly one cycle for each executed instruction.
- R8: res_rd equals bits 15:12 of the executed word.
- R9: While rst is high, every registered output reads zero.
- R10: When in_valid is low, the next cycle has res_we, ge_we and illegal low.
- R11: rd_idx_a equals instr[19:16] and rd_idx_b equals instr[3:0] in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| flag_n | input | 1 | Current negative flag |
| flag_z | input | 1 | Current zero flag |
| flag_c | input | 1 | Current carry flag |
| flag_v | input | 1 | Current overflow flag |
| src_a | input | 32 | First operand word |
| src_b | input | 32 | Second operand word |
| rd_idx_a | output | 4 | Register file read index for the first operand |
| rd_idx_b | output | 4 | Register file read index for the second operand |
| res_data | output | 32 | Packed halfword result |
| res_rd | output | 4 | Destination register index |
| res_we | output | 1 | Register write enable pulse |
| ge_out | output | 4 | New GE flags, two per lane |
| ge_we | output | 1 | GE flag update enable pulse |
| illegal | output | 1 | Valid word failed the encoding check |

## Verification
Lane values at 0x7FFF, 0x8000, 0xFFFF and 0x0000 separate a sign taken from the exact 17-bit sum from a sign taken from the wrapped halfword. They also show whether a carry out of the low lane leaks into the high lane. All fifteen condition codes are run against every one of the sixteen flag combinations, which checks both the enable pulse and the held outputs for each code. A walking one through each fixed encoding bit, plus the 4'hF condition, exercises the illegal path. Random operand words then compare both lanes and all four GE bits against an arithmetic model.

// File: rtl/phadd_pkg.sv
package phadd_pkg;

    localparam int XLEN      = 32;
    localparam int LANE_W    = 16;
    localparam int LANES     = XLEN / LANE_W;
    localparam int GE_W      = 2 * LANES;
    localparam int REG_IDX_W = 4;

    // Fixed encoding fields
    localparam logic [7:0] OPC_MAJOR = 8'h61;
    localparam logic [3:0] OPC_ONES  = 4'hF;
    localparam logic [3:0] OPC_MINOR = 4'h1;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        cond_e                 cond;
        logic [7:0]            major;
        logic [REG_IDX_W-1:0]  rn;
        logic [REG_IDX_W-1:0]  rd;
        logic [3:0]            ones;
        logic [3:0]            minor;
        logic [REG_IDX_W-1:0]  rm;
    } insn_t;

    typedef struct packed {
        logic [XLEN-1:0]      data;
        logic [REG_IDX_W-1:0] rd;
        logic [GE_W-1:0]      ge;
    } result_t;

    function automatic logic cond_pass(input cond_e cc, input flags_t f);
        logic ok;
        case (cc)
            CC_EQ:   ok = f.z;
            CC_NE:   ok = !f.z;
            CC_CS:   ok = f.c;
            CC_CC:   ok = !f.c;
            CC_MI:   ok = f.n;
            CC_PL:   ok = !f.n;
            CC_VS:   ok = f.v;
            CC_VC:   ok = !f.v;
            CC_HI:   ok = f.c && !f.z;
            CC_LS:   ok = !f.c || f.z;
            CC_GE:   ok = (f.n == f.v);
            CC_LT:   ok = (f.n != f.v);
            CC_GT:   ok = !f.z && (f.n == f.v);
            CC_LE:   ok = f.z || (f.n != f.v);
            CC_AL:   ok = 1'b1;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/phadd_decode.sv
module phadd_decode
    import phadd_pkg::*;
(
    input  logic [XLEN-1:0]      instr,
    input  flags_t               flags,
    output logic                 legal,
    output logic                 exec,
    output logic [REG_IDX_W-1:0] rd,
    output logic [REG_IDX_W-1:0] rn,
    output logic [REG_IDX_W-1:0] rm
);

    insn_t fields;
    logic  fixed_ok;

    assign fields   = insn_t'(instr);
    assign fixed_ok = (fields.major == OPC_MAJOR) &&
                      (fields.ones  == OPC_ONES)  &&
                      (fields.minor == OPC_MINOR);
    assign legal    = fixed_ok && (fields.cond != CC_NV);
    assign exec     = legal && cond_pass(fields.cond, flags);
    assign rd       = fields.rd;
    assign rn       = fields.rn;
    assign rm       = fields.rm;

    always_comb begin
        if (fields.cond == CC_NV) begin
            AST_NV_NEVER_EXECUTES: assert (!exec); // R5
        end
    end

endmodule

// File: rtl/phadd_lanes.sv
module phadd_lanes #(
    parameter int LANE_W = 16,
    parameter int LANES  = 2
) (
    input  logic [LANE_W*LANES-1:0] op_a,
    input  logic [LANE_W*LANES-1:0] op_b,
    output logic [LANE_W*LANES-1:0] sum,
    output logic [2*LANES-1:0]      ge
);

    localparam int EXT_W = LANE_W + 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [EXT_W-1:0] ext_a;
        logic signed [EXT_W-1:0] ext_b;
        logic signed [EXT_W-1:0] full;

        assign ext_a = {op_a[g*LANE_W+LANE_W-1], op_a[g*LANE_W +: LANE_W]};
        assign ext_b = {op_b[g*LANE_W+LANE_W-1], op_b[g*LANE_W +: LANE_W]};
        assign full  = ext_a + ext_b;

        assign sum[g*LANE_W +: LANE_W] = full[LANE_W-1:0];
        assign ge[2*g +: 2]            = {2{~full[LANE_W]}};

        always_comb begin
            if (!ext_a[LANE_W] && !ext_b[LANE_W]) begin
                AST_NONNEG_GE_SET: assert (ge[2*g +: 2] == 2'b11); // R2 R3
            end
            if (ext_a[LANE_W] && ext_b[LANE_W]) begin
                AST_NEG_GE_CLEAR: assert (ge[2*g +: 2] == 2'b00); // R2 R3
            end
        end
    end

endmodule

// File: rtl/phadd_unit.sv
module phadd_unit
    import phadd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [XLEN-1:0]      instr,
    input  logic                 flag_n,
    input  logic                 flag_z,
    input  logic                 flag_c,
    input  logic                 flag_v,
    input  logic [XLEN-1:0]      src_a,
    input  logic [XLEN-1:0]      src_b,
    output logic [REG_IDX_W-1:0] rd_idx_a,
    output logic [REG_IDX_W-1:0] rd_idx_b,
    output logic [XLEN-1:0]      res_data,
    output logic [REG_IDX_W-1:0] res_rd,
    output logic                 res_we,
    output logic [GE_W-1:0]      ge_out,
    output logic                 ge_we,
    output logic                 illegal
);

    flags_t               cur_flags;
    logic                 dec_legal;
    logic                 dec_exec;
    logic [REG_IDX_W-1:0] dec_rd;
    logic [XLEN-1:0]      lane_sum;
    logic [GE_W-1:0]      lane_ge;
    result_t              res_q;

    assign cur_flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

    phadd_decode u_decode (
        .instr (instr),
        .flags (cur_flags),
        .legal (dec_legal),
        .exec  (dec_exec),
        .rd    (dec_rd),
        .rn    (rd_idx_a),
        .rm    (rd_idx_b)
    );

    phadd_lanes #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_lanes (
        .op_a (src_a),
        .op_b (src_b),
        .sum  (lane_sum),
        .ge   (lane_ge)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            res_we  <= 1'b0;
            ge_we   <= 1'b0;
            illegal <= 1'b0;
        end else begin
            res_we  <= 1'b0;
            ge_we   <= 1'b0;
            illegal <= 1'b0;
            if (in_valid) begin
                if (!dec_legal) begin
                    illegal <= 1'b1;
                end else if (dec_exec) begin
                    res_we     <= 1'b1;
                    ge_we      <= 1'b1;
                    res_q.data <= lane_sum;
                    res_q.rd   <= dec_rd;
                    res_q.ge   <= lane_ge;
                end
            end
        end
    end

    assign res_data = res_q.data;
    assign res_rd   = res_q.rd;
    assign ge_out   = res_q.ge;

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!res_we && !ge_we)); // R4

    AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        illegal |-> ($stable(res_data) && $stable(ge_out) && $stable(res_rd))); // R4

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_we && !ge_we && !illegal)); // R10

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !res_we |-> ($stable(res_data) && $stable(ge_out))); // R6

endmodule

// File: tb/phadd_unit_tb_top.sv
`timescale 1ns/1ps
module phadd_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [3:0]  rd_idx_a, rd_idx_b, res_rd, ge_out;
    logic [31:0] res_data;
    logic        res_we, ge_we, illegal;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    phadd_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .src_a(src_a), .src_b(src_b), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
        .res_data(res_data), .res_rd(res_rd), .res_we(res_we),
        .ge_out(ge_out), .ge_we(ge_we), .illegal(illegal)
    );

    localparam int NV = 8;
    localparam logic [31:0] T_A [NV] = '{32'h7FFF_7FFF, 32'h8000_8000, 32'h0000_0000,
        32'hFFFF_0001, 32'h8000_7FFF, 32'h0005_FFFE, 32'h1234_8000, 32'hFFFF_FFFF};
    localparam logic [31:0] T_B [NV] = '{32'h0001_0001, 32'hFFFF_FFFF, 32'h0000_0000,
        32'h0001_FFFF, 32'h8000_7FFF, 32'hFFF0_0001, 32'h0001_8000, 32'h0001_0000};
    localparam logic [31:0] T_R [NV] = '{32'h8000_8000, 32'h7FFF_7FFF, 32'h0000_0000,
        32'h0000_0000, 32'h0000_FFFE, 32'hFFF5_FFFF, 32'h1235_0000, 32'h0000_FFFF};
    localparam logic [3:0]  T_G [NV] = '{4'b1111, 4'b0000, 4'b1111,
        4'b1111, 4'b0011, 4'b0000, 4'b1100, 4'b1100};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] cc, input logic [3:0] rn,
                                       input logic [3:0] rd, input logic [3:0] rm);
        return {cc, 8'h61, rn, rd, 4'hF, 4'h1, rm};
    endfunction

    function automatic logic m_pass(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            4'd0: return z;          4'd1: return !z;
            4'd2: return c;          4'd3: return !c;
            4'd4: return n;          4'd5: return !n;
            4'd6: return v;          4'd7: return !v;
            4'd8: return c && !z;    4'd9: return !c || z;
            4'd10: return n == v;    4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [35:0] m_add(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic [3:0]  g;
        for (int l = 0; l < 2; l++) begin
            int s;
            s = int'($signed(a[16*l +: 16])) + int'($signed(b[16*l +: 16]));
            r[16*l +: 16] = s[15:0];
            g[2*l +: 2]   = (s >= 0) ? 2'b11 : 2'b00;
        end
        return {g, r};
    endfunction

    task automatic issue(input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic [3:0] f);
        @(negedge clk);
        instr = w; src_a = a; src_b = b;
        {flag_n, flag_z, flag_c, flag_v} = f;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] held_d;
        logic [3:0]  held_g;
        logic [35:0] m;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 data", res_data, 32'h0);
        chk("R9 flags", {26'h0, res_we, ge_we, illegal, ge_out[2:0]}, 32'h0);
        chk("R9 ge", {28'h0, ge_out}, 32'h0);
        rst = 1'b0;

        // R11: read indices are combinational
        @(negedge clk);
        instr = mk(4'hE, 4'h9, 4'h2, 4'h6);
        #1;
        chk("R11 index a", {28'h0, rd_idx_a}, 32'h9);
        chk("R11 index b", {28'h0, rd_idx_b}, 32'h6);

        // Vector table: R1 R2 R3 R8
        for (int i = 0; i < NV; i++) begin
            issue(mk(4'hE, 4'h1, 4'(i + 3), 4'h2), T_A[i], T_B[i], 4'h0);
            chk("R1 lane result", res_data, T_R[i]);
            chk("R2 low ge", {30'h0, ge_out[1:0]}, {30'h0, T_G[i][1:0]});
            chk("R3 high ge", {30'h0, ge_out[3:2]}, {30'h0, T_G[i][3:2]});
            chk("R8 dest", {28'h0, res_rd}, 32'(i + 3));
            chk("R7 enables", {30'h0, res_we, ge_we}, 32'h3);
            @(negedge clk);
            chk("R7 single pulse", {30'h0, res_we, ge_we}, 32'h0);
        end

        // R7: back-to-back instructions each write once
        @(negedge clk);
        instr = mk(4'hE, 4'h0, 4'h4, 4'h0); src_a = 32'h0001_0001; src_b = 32'h0001_0001;
        in_valid = 1'b1;
        @(negedge clk);
        chk("R7 first of pair", res_data, 32'h0002_0002);
        src_a = 32'h0003_0003;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 second of pair", {res_data[31:1], res_we}, {32'h0004_0004 >> 1, 1'b1});

        // R6: every condition code against every flag set
        for (int cc = 0; cc < 15; cc++) begin
            for (int f = 0; f < 16; f++) begin
                logic [31:0] a, b;
                logic        p;
                a = $urandom; b = $urandom;
                held_d = res_data; held_g = ge_out;
                p = m_pass(4'(cc), 4'(f));
                issue(mk(4'(cc), 4'h3, 4'h5, 4'h7), a, b, 4'(f));
                m = m_add(a, b);
                chk("R6 cond enable", {29'h0, res_we, ge_we, illegal}, {29'h0, p, p, 1'b0});
                chk("R6 cond data", res_data, p ? m[31:0] : held_d);
                chk("R6 cond ge", {28'h0, ge_out}, {28'h0, p ? m[35:32] : held_g});
            end
        end

        // R5: condition 4'hF is illegal
        held_d = res_data; held_g = ge_out;
        issue(mk(4'hF, 4'h1, 4'h8, 4'h2), 32'h1111_1111, 32'h2222_2222, 4'h0);
        chk("R5 illegal", {29'h0, illegal, res_we, ge_we}, 32'h4);
        chk("R5 held data", res_data, held_d);
        chk("R5 held ge", {28'h0, ge_out}, {28'h0, held_g});

        // R4: flip each fixed encoding bit
        for (int bitn = 4; bitn < 28; bitn++) begin
            if (bitn >= 12 && bitn < 20) continue;
            held_d = res_data; held_g = ge_out;
            issue(mk(4'hE, 4'h1, 4'h8, 4'h2) ^ (32'h1 << bitn),
                  32'h1111_1111, 32'h2222_2222, 4'h0);
            chk("R4 illegal", {29'h0, illegal, res_we, ge_we}, 32'h4);
            chk("R4 held data", res_data, held_d);
            chk("R4 held ge", {28'h0, ge_out}, {28'h0, held_g});
            @(negedge clk);
            chk("R4 illegal pulse", {31'h0, illegal}, 32'h0);
        end

        // R10: legal word without valid does nothing
        held_d = res_data;
        @(negedge clk);
        instr = mk(4'hE, 4'h1, 4'h8, 4'h2); src_a = 32'h5555_5555; src_b = 32'h1;
        repeat (3) begin
            @(negedge clk);
            chk("R10 idle enables", {29'h0, res_we, ge_we, illegal}, 32'h0);
            chk("R10 idle data", res_data, held_d);
        end

        // R1 R2 R3: random operands
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            a = $urandom; b = $urandom;
            if (i % 4 == 0) a[15:0] = 16'h7FFF;
            if (i % 4 == 1) b[31:16] = 16'h8000;
            if (i % 4 == 2) a[31:16] = 16'hFFFF;
            issue(mk(4'hE, 4'h0, 4'h1, 4'h0), a, b, 4'($urandom));
            m = m_add(a, b);
            chk("R1 random result", res_data, m[31:0]);
            chk("R2 R3 random ge", {28'h0, ge_out}, {28'h0, m[35:32]});
        end

        // R9: reset in mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid reset data", res_data, 32'h0);
        chk("R9 mid reset ctl", {24'h0, res_rd, res_we, ge_we, illegal, 1'b0}, 32'h0);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule